// File: doc/BRIEF.md
# Sequential Subtract-and-Count Divider

This block divides an unsigned dividend by an unsigned divisor that is only known at run time, so a divide operator cannot be built. It spreads the work over many clocks. Each busy clock takes the divisor once off a running remainder and adds one to a quotient counter. The run stops as soon as the remainder is smaller than the divisor. A typical client scales a waveform phase counter: it forms `count * 255` as the dividend and passes the run-time period `n` as the divisor.

The caller drives the operands and pulses `start` while the block is idle. `busy` then stays high until the result is ready. `done` pulses for one cycle with the quotient, the remainder and an error flag. Two cases skip the iteration. If the divisor is a power of two, the block shifts the dividend right and masks the low bits in a single step. If the divisor is zero, the block finishes in one step and flags an error. The iterative latency grows with the quotient value. It does not depend on the operand width.

Controller states and transitions:
- IDLE → RUN on `start`, which latches the operands.
- RUN → FIN for one of three reasons: the divisor is zero (zero exit), the divisor is a power of two (shift exit), or the remainder is below the divisor (count exit).
- RUN → RUN while the remainder is not below the divisor (subtract step).
- FIN → IDLE always, after the single `done` cycle.

Top module: `subdiv_top`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `done`, `div_err`, `quotient` and `remainder` to zero. This holds also when `rst` arrives in the middle of a division.
- R2: A `start` sampled high in IDLE latches `dividend` and `divisor`. `busy` is high from the next cycle until the result is ready. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R3: For a nonzero divisor that is not a power of two, the completion reports `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor, with `div_err` low.
- R4: Take the clock edge that samples `start` as edge 0. For a nonzero divisor that is not a power of two, `done` is first high after edge q+1, where q is the resulting quotient.
- R5: For a power-of-two divisor 2^k, including 1, `done` is high after edge 1. The results are `quotient` = dividend >> k and `remainder` = the low k bits of the dividend, with `div_err` low.
- R6: For a zero divisor, `done` is high after edge 1. `div_err` is 1, `quotient` is all ones (0xFFFF) and `remainder` equals the dividend.
- R7: While `busy` is high, changes on `dividend`, `divisor` and `start` have no effect on the result or on the latency.
- R8: After `done`, `quotient`, `remainder` and `div_err` keep their values, and `done` stays low, until the next accepted `start`.
- R9: The 16-bit quotient counter does not wrap. A dividend of 65535 with divisor 3 yields quotient 21845 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only in IDLE |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last division had a zero divisor |
| quotient | output | WIDTH | Quotient of the last division |
| remainder | output | WIDTH | Remainder of the last division |

## Verification
The bench builds the block with the default WIDTH of 16. At that width the worst iterative case, 65535 / 3, can run to its full 21846-cycle latency. The bench can therefore confirm the exact q+1 timing and that the counter does not wrap. Random divisors are kept at 64 or above so that many random divisions fit in the run. Separate directed and random passes cover every power of two from 1 to 32768, the zero divisor, quotients of 0 and 1, the scaled `count*255/n` use, and input scrambling while the block is busy.

// File: rtl/subdiv_pkg.sv
`timescale 1ns/1ps
package subdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } div_state_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_SUB,
        OP_SHIFT,
        OP_ZERO
    } dp_op_t;
endpackage

// File: rtl/subdiv_pow2.sv
`timescale 1ns/1ps
module subdiv_pow2 #(
    parameter int WIDTH = 16,
    localparam int SW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_pow2,
    output logic [SW-1:0]    shamt
);
    // exactly one bit set
    assign is_pow2 = (value != '0) && ((value & (value - 1'b1)) == '0);

    // index of the highest set bit; equals log2 when is_pow2
    always_comb begin
        shamt = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (value[i]) shamt = SW'(i);
        end
    end
endmodule

// File: rtl/subdiv_ctrl.sv
`timescale 1ns/1ps
module subdiv_ctrl
    import subdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       div_zero,
    input  logic       div_pow2,
    input  logic       rem_below,
    output dp_op_t     op,
    output logic       busy,
    output logic       done
);
    div_state_t state, state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // transitions and datapath command
    always_comb begin
        state_nxt = state;
        op        = OP_HOLD;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_RUN;
                    op        = OP_LOAD;
                end
            end
            ST_RUN: begin
                if (div_zero) begin
                    state_nxt = ST_FIN;
                    op        = OP_ZERO;
                end else if (div_pow2) begin
                    state_nxt = ST_FIN;
                    op        = OP_SHIFT;
                end else if (rem_below) begin
                    state_nxt = ST_FIN;
                end else begin
                    op        = OP_SUB;
                end
            end
            ST_FIN: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // status outputs
    always_comb begin
        busy = (state == ST_RUN);
        done = (state == ST_FIN);
    end

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/subdiv_dp.sv
`timescale 1ns/1ps
module subdiv_dp
    import subdiv_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_op_t           op,
    input  logic             active,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    input  logic [SW-1:0]    shamt,
    output logic [WIDTH-1:0] divisor_q,
    output logic             div_zero,
    output logic             rem_below,
    output logic [WIDTH-1:0] quo_q,
    output logic [WIDTH-1:0] rem_q,
    output logic             err_q
);
    logic [WIDTH-1:0] num_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q     <= '0;
            divisor_q <= '0;
            quo_q     <= '0;
            rem_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    num_q     <= dividend;
                    divisor_q <= divisor;
                    rem_q     <= dividend;
                    quo_q     <= '0;
                    err_q     <= 1'b0;
                end
                OP_SUB: begin
                    rem_q <= rem_q - divisor_q;
                    quo_q <= quo_q + 1'b1;
                end
                OP_SHIFT: begin
                    quo_q <= rem_q >> shamt;
                    rem_q <= rem_q & (divisor_q - 1'b1);
                end
                OP_ZERO: begin
                    quo_q <= '1;
                    rem_q <= num_q;
                    err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign div_zero  = (divisor_q == '0);
    assign rem_below = (rem_q < divisor_q);

    p_operands_held_r7: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LOAD) |=> ($stable(num_q) && $stable(divisor_q)));
    p_sum_invariant_r3: assert property (@(posedge clk) disable iff (rst)
        (active && !err_q) |->
        ((2*WIDTH)'(quo_q) * (2*WIDTH)'(divisor_q) + (2*WIDTH)'(rem_q) == (2*WIDTH)'(num_q)));
    p_zero_result_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ZERO) |=> (err_q && (quo_q == '1) && (rem_q == num_q)));
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB) |=> (quo_q != '0));
endmodule

// File: rtl/subdiv_top.sv
`timescale 1ns/1ps
module subdiv_top
    import subdiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_err,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    localparam int SW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    dp_op_t           op;
    logic             div_zero, div_pow2, rem_below;
    logic [SW-1:0]    shamt;
    logic [WIDTH-1:0] divisor_q;

    subdiv_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .div_zero  (div_zero),
        .div_pow2  (div_pow2),
        .rem_below (rem_below),
        .op        (op),
        .busy      (busy),
        .done      (done)
    );

    subdiv_pow2 #(.WIDTH(WIDTH)) u_pow2 (
        .value   (divisor_q),
        .is_pow2 (div_pow2),
        .shamt   (shamt)
    );

    subdiv_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .active    (busy | done),
        .dividend  (dividend),
        .divisor   (divisor),
        .shamt     (shamt),
        .divisor_q (divisor_q),
        .div_zero  (div_zero),
        .rem_below (rem_below),
        .quo_q     (quotient),
        .rem_q     (remainder),
        .err_q     (div_err)
    );

    p_final_rem_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !div_err) |-> (remainder < divisor_q));
    p_results_held_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !done) |=> ($stable(quotient) && $stable(remainder) && $stable(div_err)));
endmodule

// File: tb/subdiv_top_test.sv
`timescale 1ns/1ps
module subdiv_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_err;
    logic [15:0] quotient, remainder;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    subdiv_top #(.WIDTH(16)) uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_err(div_err), .quotient(quotient), .remainder(remainder)
    );

    function automatic bit is_p2(input logic [15:0] b);
        return (b != 0) && ((b & (b - 16'd1)) == 0);
    endfunction
    function automatic logic [15:0] exp_q(input logic [15:0] a, input logic [15:0] b);
        return (b == 0) ? 16'hFFFF : a / b;
    endfunction
    function automatic logic [15:0] exp_r(input logic [15:0] a, input logic [15:0] b);
        return (b == 0) ? a : a % b;
    endfunction
    function automatic int exp_lat(input logic [15:0] a, input logic [15:0] b);
        if (b == 0 || is_p2(b)) return 1;
        return int'(a / b) + 1;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_div(input logic [15:0] a, input logic [15:0] b, input bit scramble, input string req);
        int n = 0;
        logic [15:0] hq, hr;
        logic        he;
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R2", "busy after start", {31'd0, busy}, 32'd1);
        while (n < 70000) begin
            if (scramble) begin
                dividend = 16'($urandom);
                divisor  = 16'($urandom);
                start    = 1'($urandom);
            end
            @(posedge clk); #1;
            n++;
            if (done) break;
            if (!busy) begin
                chk("R2", "busy dropped early", 32'd0, 32'd1);
                break;
            end
        end
        start = 1'b0;
        chk(req, "latency", n, exp_lat(a, b));
        chk("R2", "busy low at done", {31'd0, busy}, 32'd0);
        chk(req, "quotient", {16'd0, quotient}, {16'd0, exp_q(a, b)});
        chk(req, "remainder", {16'd0, remainder}, {16'd0, exp_r(a, b)});
        chk(req, "div_err", {31'd0, div_err}, {31'd0, (b == 0)});
        hq = quotient; hr = remainder; he = div_err;
        for (int k = 0; k < 3; k++) begin
            dividend = 16'($urandom);
            divisor  = 16'($urandom);
            @(posedge clk); #1;
            chk("R2", "done one cycle", {31'd0, done}, 32'd0);
        end
        chk("R8", "held outputs", {hq, hr}, {quotient, remainder});
        chk("R8", "held err", {31'd0, he}, {31'd0, div_err});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", "reset state", {busy, done, div_err, 13'd0, quotient | remainder}, 32'd0);

        // directed corner cases
        run_div(16'd65535, 16'd3, 1'b0, "R9");
        run_div(16'd0,     16'd7, 1'b0, "R4");
        run_div(16'd5,     16'd7, 1'b0, "R4");
        run_div(16'd14,    16'd7, 1'b0, "R3");
        run_div(16'd65535, 16'd65535, 1'b0, "R3");
        run_div(16'(200 * 255), 16'd300, 1'b0, "R3");
        run_div(16'd1234,  16'd1, 1'b0, "R5");
        run_div(16'd65535, 16'd32768, 1'b0, "R5");
        run_div(16'd1234,  16'd0, 1'b0, "R6");
        run_div(16'd0,     16'd0, 1'b0, "R6");
        run_div(16'd1000,  16'd7, 1'b1, "R7");
        run_div(16'd777,   16'd0, 1'b1, "R7");

        for (int k = 0; k < 16; k++) run_div(16'($urandom), 16'(1 << k), 1'b0, "R5");
        for (int i = 0; i < 50; i++) begin
            a = 16'($urandom);
            b = 16'(64 + ($urandom % (65536 - 64)));
            run_div(a, b, (i % 3) == 0, (i % 3) == 0 ? "R7" : "R3");
        end

        // reset in the middle of a long division
        @(negedge clk);
        start = 1'b1; dividend = 16'd60000; divisor = 16'd3;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1", "mid-run reset", {busy, done, div_err, 13'd0, quotient | remainder}, 32'd0);
        @(negedge clk); rst = 1'b0;
        run_div(16'd100, 16'd9, 1'b0, "R3");

        if (!ended) begin
            ended = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule